// File: doc/BRIEF.md
# Timing-Qualified I2C Bus Condition Detector

This block watches the serial clock and serial data lines of an I2C bus and reports START and STOP conditions. It passes both lines through two-flop synchronizers, then measures three intervals around every data-line transition seen while the clock line is high. The intervals are how long the clock line has been high, how long the data line held its previous level, and how long the clock line stays high with data steady after the change. A condition is reported only when all three intervals exceed minimum cycle counts. A plain edge detector would accept a noise spike on the data line as a bus condition, and this block rejects it.

Two threshold sets are built in. One suits standard-rate buses and the other fast buses, both expressed in cycles of a 4 MHz system clock. A mode input picks the active set. Each accepted condition produces a one-cycle pulse. An accepted STOP while the master-mode input is low also sets a sticky interrupt request. Software clears the request with a clear strobe.

Top module: `bus_cond_qualifier`

## Requirements
- R1: While rst_n is low at a rising clock edge, start_pulse, stop_pulse and stop_irq are 0 after that edge. The synchronizers treat both lines as high, and all interval counters restart from zero.
- R2: A falling data line while the clock line is high yields exactly one start_pulse cycle. A rising data line while the clock line is high yields exactly one stop_pulse cycle. The two pulses never coincide.
- R3: A transition is rejected unless the clock line was high for more than REL cycles before it. REL is 26 in standard mode and 4 in fast mode. Release time is counted from the clock rise to the data change at the pins.
- R4: A transition is rejected unless the data line held its previous level for more than SU cycles. SU is 13 in standard mode and 2 in fast mode. In fast mode, a data low glitch of 2 cycles on an idle bus therefore yields no pulse, and a glitch of 3 cycles yields one START and then one STOP.
- R5: A transition is discarded without a pulse unless the clock line stays high with data steady for more than HD cycles after the data change. HD is 13 in standard mode and 2 in fast mode.
- R6: The pulse is high in the clock cycle that follows the (HD+3)-th rising edge, counting the first edge that samples the new data level as edge 1. It is low on the edges before and after that cycle.
- R7: hs_mode=1 selects the fast set (4/2/2). hs_mode=0 selects the standard set (26/13/13). A condition that meets only the fast set is rejected in standard mode.
- R8: stop_irq is set by an accepted STOP when master_mode is 0. It is not set by a STOP accepted while master_mode is 1, and it is never set by a START.
- R9: stop_irq stays set until irq_clr is high at a rising edge. If a setting STOP completes on the same edge as a clear, the set wins.
- R10: A data line change while the clock line is low produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (4 MHz nominal for the built-in thresholds) |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line level |
| sda_in | input | 1 | Raw bus data line level |
| hs_mode | input | 1 | 1 selects fast thresholds, 0 selects standard thresholds |
| master_mode | input | 1 | 1 when the host controller is bus master |
| irq_clr | input | 1 | Clears stop_irq |
| start_pulse | output | 1 | One-cycle pulse for an accepted START |
| stop_pulse | output | 1 | One-cycle pulse for an accepted STOP |
| stop_irq | output | 1 | Sticky request raised by an accepted STOP in slave mode |

## Verification
A stuck or miscounting interval counter shows up as a boundary failure. It either accepts a transition at exactly the threshold count or rejects one at threshold plus one, and the error appears within a single bus condition, about 30 to 60 cycles. A pending event that is not dropped on a clock fall, or not retired after it fires, produces a missing, extra or two-cycle pulse within HD+3 edges of the data change. A corrupted interrupt latch shows up as stop_irq failing to hold, or failing to set on the same edge as a clear.

// File: rtl/bus_cond_pkg.sv
`timescale 1ns/1ps
// Shared types for the bus condition detector.
package bus_cond_pkg;
    typedef enum logic {
        COND_START = 1'b0,
        COND_STOP  = 1'b1
    } cond_kind_e;
endpackage

// File: rtl/bus_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer for W asynchronous inputs.
// Assumes each input is a level that stays put for several clocks.
// Reset loads RST_VAL, which is the idle level of the bus lines.
module bus_sync #(
    parameter int             W       = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Shift the raw level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/span_counter.sv
`timescale 1ns/1ps
// Saturating interval counter.
// load has priority and loads load_val. Otherwise inc adds one, and the
// count holds at all ones. With neither input high, the count returns to 0.
module span_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] SAT = '1;

    // Load, count up with saturation, or restart.
    always_ff @(posedge clk) begin
        if (!rst_n)          count <= '0;
        else if (load)       count <= load_val;
        else if (inc)        count <= (count == SAT) ? SAT : count + 1'b1;
        else                 count <= '0;
    end
endmodule

// File: rtl/cond_limits.sv
`timescale 1ns/1ps
// Selects the minimum release, setup and hold cycle counts for the mode.
// hs_mode may change at any time. Assumes every threshold fits in W bits
// with room for one more count.
module cond_limits #(
    parameter int W      = 5,
    parameter int STD_RL = 26,
    parameter int STD_SU = 13,
    parameter int STD_HD = 13,
    parameter int FST_RL = 4,
    parameter int FST_SU = 2,
    parameter int FST_HD = 2
) (
    input  logic         hs_mode,
    output logic [W-1:0] rel_min,
    output logic [W-1:0] su_min,
    output logic [W-1:0] hd_min
);
    // Choose the threshold set.
    always_comb begin
        if (hs_mode) begin
            rel_min = W'(FST_RL);
            su_min  = W'(FST_SU);
            hd_min  = W'(FST_HD);
        end else begin
            rel_min = W'(STD_RL);
            su_min  = W'(STD_SU);
            hd_min  = W'(STD_HD);
        end
    end
endmodule

// File: rtl/bus_cond_qualifier.sv
`timescale 1ns/1ps
// Bus START/STOP detector with timing qualification.
// The block synchronizes both lines and looks for a data transition while
// the clock line is high. It accepts the transition only if the clock line
// had been high for more than the release minimum and the data line had held
// its old level for more than the setup minimum. The accepted transition is
// then held pending. If the clock line stays high with data steady for more
// than the hold minimum, the block emits a one-cycle pulse. If the clock
// line falls or the data line moves first, the pending event is dropped.
// Assumes synchronous active-low reset and an idle bus at reset.
module bus_cond_qualifier #(
    parameter int STD_RL = 26,
    parameter int STD_SU = 13,
    parameter int STD_HD = 13,
    parameter int FST_RL = 4,
    parameter int FST_SU = 2,
    parameter int FST_HD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic hs_mode,
    input  logic master_mode,
    input  logic irq_clr,
    output logic start_pulse,
    output logic stop_pulse,
    output logic stop_irq
);
    import bus_cond_pkg::*;

    localparam int MAX_A = (STD_RL > FST_RL) ? STD_RL : FST_RL;
    localparam int MAX_B = (STD_SU > FST_SU) ? STD_SU : FST_SU;
    localparam int MAX_C = (STD_HD > FST_HD) ? STD_HD : FST_HD;
    localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_T  = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int CW     = $clog2(MAX_T + 2);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [1:0]    line_s;
    logic          scl_s, sda_s, scl_d, sda_d;
    logic          sda_edge, qualified, steady_hi, fire;
    logic          pending;
    cond_kind_e    kind;
    logic [CW-1:0] rel_cnt, su_cnt, hd_cnt;
    logic [CW-1:0] rel_min, su_min, hd_min;

    bus_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    cond_limits #(
        .W(CW), .STD_RL(STD_RL), .STD_SU(STD_SU), .STD_HD(STD_HD),
        .FST_RL(FST_RL), .FST_SU(FST_SU), .FST_HD(FST_HD)
    ) u_lim (
        .hs_mode(hs_mode), .rel_min(rel_min), .su_min(su_min), .hd_min(hd_min)
    );

    // Release span: cycles since the clock line went high.
    span_counter #(.W(CW)) u_rel (
        .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0),
        .inc(scl_s), .count(rel_cnt)
    );

    // Setup span: cycles the data line has held its level.
    span_counter #(.W(CW)) u_su (
        .clk(clk), .rst_n(rst_n), .load(sda_s != sda_d), .load_val(ONE),
        .inc(1'b1), .count(su_cnt)
    );

    // Hold span: cycles since the accepted transition.
    span_counter #(.W(CW)) u_hd (
        .clk(clk), .rst_n(rst_n), .load(qualified), .load_val(ONE),
        .inc(pending && !fire), .count(hd_cnt)
    );

    // Decide whether a transition qualifies and when the pending one fires.
    always_comb begin
        sda_edge  = scl_s && scl_d && (sda_s != sda_d);
        qualified = sda_edge && (rel_cnt > rel_min) && (su_cnt > su_min);
        steady_hi = scl_s && (sda_s == sda_d);
        fire      = pending && steady_hi && (hd_cnt >= hd_min);
    end

    // Track the pending event and its kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            kind    <= COND_START;
        end else if (qualified) begin
            pending <= 1'b1;
            kind    <= sda_s ? COND_STOP : COND_START;
        end else if (fire || !steady_hi) begin
            pending <= 1'b0;
        end
    end

    // Register the pulses and the sticky interrupt (set beats clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
            stop_irq    <= 1'b0;
        end else begin
            start_pulse <= fire && (kind == COND_START);
            stop_pulse  <= fire && (kind == COND_STOP);
            if (fire && (kind == COND_STOP) && !master_mode) stop_irq <= 1'b1;
            else if (irq_clr)                                stop_irq <= 1'b0;
        end
    end
endmodule

// File: rtl/bus_cond_checks.sv
`timescale 1ns/1ps
// Property checks for bus_cond_qualifier, attached through bind.
module bus_cond_checks (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic master_mode,
    input logic irq_clr,
    input logic start_pulse,
    input logic stop_pulse,
    input logic stop_irq
);
    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    p_stop_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse);
    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_pulse && stop_pulse));
    p_clock_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse || stop_pulse) |-> $past(scl_s));
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_irq) |-> stop_pulse);
    p_irq_slave_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pulse && !$past(master_mode)) |-> stop_irq);
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_irq && !irq_clr) |=> stop_irq);
    p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> (!stop_irq || stop_pulse));
endmodule

bind bus_cond_qualifier bus_cond_checks u_checks (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .master_mode(master_mode),
    .irq_clr(irq_clr), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .stop_irq(stop_irq)
);

// File: tb/test_bus_cond_qualifier.sv
`timescale 1ns/1ps
module test_bus_cond_qualifier;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic hs_mode = 1'b0, master_mode = 1'b0, irq_clr = 1'b0;
    logic start_pulse, stop_pulse, stop_irq;

    int checks = 0, failures = 0;
    int n_start = 0, n_stop = 0;

    always #2 clk = ~clk;

    bus_cond_qualifier i_bus_cond_qualifier (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .hs_mode(hs_mode), .master_mode(master_mode), .irq_clr(irq_clr),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse), .stop_irq(stop_irq)
    );

    // Count pulses away from the active edge.
    always @(negedge clk) begin
        if (start_pulse) n_start++;
        if (stop_pulse)  n_stop++;
    end

    typedef struct packed {
        logic hs; logic mst; logic stp;
        int rel; int su; int hd;
        int e_start; int e_stop; logic e_irq;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 30, 30, 20, 1, 0, 1'b0}, // R2 std START
        '{1'b0, 1'b0, 1'b1, 27, 27, 14, 0, 1, 1'b1}, // R3/R5 boundary pass, R8
        '{1'b0, 1'b0, 1'b0, 26, 40, 20, 0, 0, 1'b0}, // R3 release at limit
        '{1'b0, 1'b0, 1'b1, 30, 30, 13, 0, 0, 1'b0}, // R5 hold at limit
        '{1'b1, 1'b0, 1'b0,  5,  5,  3, 1, 0, 1'b0}, // R7 fast START
        '{1'b1, 1'b0, 1'b1,  4,  8, 10, 0, 0, 1'b0}, // R3 fast release limit
        '{1'b1, 1'b0, 1'b1,  5,  5,  2, 0, 0, 1'b0}, // R5 fast hold limit
        '{1'b1, 1'b1, 1'b1,  6,  6,  5, 0, 1, 1'b0}, // R8 master STOP
        '{1'b0, 1'b0, 1'b1, 10, 10, 10, 0, 0, 1'b0}, // R7 fast timing, std mode
        '{1'b1, 1'b0, 1'b1,  5,  5,  3, 0, 1, 1'b1}  // R8 fast slave STOP
    };

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Build one condition from release, setup and hold lengths in cycles.
    task automatic drive_cond(input logic stp, input int rel, input int su,
                              input int hd);
        @(negedge clk) scl_in = 1'b0;
        wt(2); sda_in = stp;
        wt(2); sda_in = ~stp;
        wt(su - rel); scl_in = 1'b1;
        wt(rel); sda_in = stp;
        wt(hd); scl_in = 1'b0;
        wt(2); sda_in = 1'b1;
        wt(2); scl_in = 1'b1;
        wt(40);
    endtask

    task automatic pulse_clr();
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        wt(5);
        chk("R1 start", int'(start_pulse), 0);
        chk("R1 stop", int'(stop_pulse), 0);
        chk("R1 irq", int'(stop_irq), 0);
        rst_n = 1'b1;
        wt(40);

        // Table of conditions
        for (int i = 0; i < NV; i++) begin
            hs_mode = VECS[i].hs;
            master_mode = VECS[i].mst;
            pulse_clr();
            wt(5);
            n_start = 0; n_stop = 0;
            drive_cond(VECS[i].stp, VECS[i].rel, VECS[i].su, VECS[i].hd);
            chk($sformatf("R2/R3/R5/R7 v%0d start", i), n_start, VECS[i].e_start);
            chk($sformatf("R2/R3/R5/R7 v%0d stop", i), n_stop, VECS[i].e_stop);
            chk($sformatf("R8 v%0d irq", i), int'(stop_irq), int'(VECS[i].e_irq));
        end

        // R4: short data glitches on an idle bus, fast mode
        hs_mode = 1'b1; master_mode = 1'b1;
        wt(10); n_start = 0; n_stop = 0;
        sda_in = 1'b0; wt(2); sda_in = 1'b1; wt(30);
        chk("R4 glitch2 start", n_start, 0);
        chk("R4 glitch2 stop", n_stop, 0);
        n_start = 0; n_stop = 0;
        sda_in = 1'b0; wt(3); sda_in = 1'b1; wt(30);
        chk("R4 glitch3 start", n_start, 1);
        chk("R4 glitch3 stop", n_stop, 1);

        // R10: data toggles while the clock line is low
        n_start = 0; n_stop = 0;
        scl_in = 1'b0; wt(4);
        for (int k = 0; k < 6; k++) begin sda_in = ~sda_in; wt(10); end
        sda_in = 1'b1; wt(3); scl_in = 1'b1; wt(30);
        chk("R10 start", n_start, 0);
        chk("R10 stop", n_stop, 0);

        // R6: exact latency of a fast START (HD=2, pulse after edge 5)
        master_mode = 1'b0;
        scl_in = 1'b0; wt(3); scl_in = 1'b1; wt(8);
        sda_in = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            chk($sformatf("R6 start edge%0d", k), int'(start_pulse), (k == 5) ? 1 : 0);
        end
        wt(5); scl_in = 1'b0; wt(3); sda_in = 1'b1; wt(3); scl_in = 1'b1; wt(20);

        // R9: set wins over clear on the same edge, then sticky, then clear
        pulse_clr(); wt(2);
        scl_in = 1'b0; wt(2); sda_in = 1'b0; wt(3); scl_in = 1'b1; wt(8);
        sda_in = 1'b1;
        wt(4); irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        chk("R9 stop pulse", int'(stop_pulse), 1);
        chk("R9 set wins", int'(stop_irq), 1);
        wt(20);
        chk("R9 sticky", int'(stop_irq), 1);
        pulse_clr();
        chk("R9 cleared", int'(stop_irq), 0);

        // R1: reset asserted mid-operation clears the flag
        hs_mode = 1'b1;
        drive_cond(1'b1, 6, 6, 5);
        chk("R8 before reset", int'(stop_irq), 1);
        rst_n = 1'b0; wt(2);
        chk("R1 irq after reset", int'(stop_irq), 0);
        rst_n = 1'b1; wt(5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule